// File: doc/BRIEF.md
# Nibble-RAM Stack Pointer Controller

This block keeps the return stack of a small nibble-oriented CPU. The stack lives in a nibble-wide data RAM that sits outside the block. A frame holds a 14-bit program counter together with the carry and status flags, so it spans exactly four nibbles. The 10-bit pointer always has its top four bits at 1111 and its two lowest bits at 11. Only a 4-bit frame index moves, which gives room for sixteen frames. Pushes and pops wrap around inside that window, and nothing detects overflow or underflow.

A call or interrupt entry starts a push. The block then drives one RAM write per cycle for four cycles and afterwards moves the pointer down by one frame. A return starts a pop. The block reads the four nibbles back, moves the pointer up by one frame, and presents the restored program counter and flags for one cycle. The pointer can also be reloaded to its top value by a strobe that is raised when software clears the reset-stack-pointer control bit.

Top module: `nib_stack_ctrl`

## Requirements
- R1: After the asynchronous reset, sp_o is 0x3FF, busy_o is low and neither RAM strobe is active.
- R2: A push accepted while idle produces four write cycles. Cycle k (k = 0..3) writes nibble k of the 16-bit word {status (bit 15), carry (bit 14), pc (bits 13:0)}, where nibble k is bits 4k+3..4k, to address sp_o - k. The values used are those of pc_i, carry_i and status_i when the push is accepted.
- R3: The pointer moves down by 4 at the clock edge that ends the fourth write. Bits 9:6 always read 1111 and bits 1:0 always read 11. From 0x3C3 a push wraps to 0x3FF.
- R4: On an interrupt push (push_irq_i high at acceptance) ram_wmask_o is 1111 in every write cycle. On a plain call push it is 0011 in the fourth write cycle, so the two flag bits held in RAM are kept, and 1111 in the other three.
- R5: A pop accepted while idle produces four read cycles at sp_o+4, sp_o+3, sp_o+2 and sp_o+1, in that order. The pointer then moves up by 4, and from 0x3FF it wraps to 0x3C3.
- R6: In the cycle after the fourth read, ret_valid_o is high for exactly one cycle. In that cycle ret_pc_o, ret_carry_o and ret_status_o carry the fields of the word that was read, which has the same layout as in R2.
- R7: busy_o is high in exactly the four access cycles of a push or a pop. push_i and pop_i have no effect while busy_o is high.
- R8: When push_i and pop_i are both high in an idle cycle, the push is taken and the pop is dropped.
- R9: sp_reinit_i sets sp_o to 0x3FF on the next edge. It ends any push or pop in progress without a pointer step and without ret_valid_o, and it takes priority over push_i and pop_i.
- R10: ram_we_o and ram_re_o are never high together, and neither is high while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| push_i | input | 1 | Start a push (call or interrupt entry) |
| push_irq_i | input | 1 | Push is an interrupt entry, so the flags are written |
| pop_i | input | 1 | Start a pop (return) |
| sp_reinit_i | input | 1 | Reload the pointer to its top value and end any operation |
| pc_i | input | 14 | Program counter to save |
| carry_i | input | 1 | Carry flag to save |
| status_i | input | 1 | Status flag to save |
| ram_rdata_i | input | 4 | RAM read data, valid in the same cycle as the address |
| sp_o | output | 10 | Current stack pointer |
| busy_o | output | 1 | A push or pop is in progress |
| ram_addr_o | output | 10 | RAM nibble address |
| ram_we_o | output | 1 | RAM write strobe |
| ram_wdata_o | output | 4 | RAM write data |
| ram_wmask_o | output | 4 | Per-bit write enable |
| ram_re_o | output | 1 | RAM read strobe |
| ret_valid_o | output | 1 | One-cycle pulse when a popped frame is ready |
| ret_pc_o | output | 14 | Restored program counter |
| ret_carry_o | output | 1 | Restored carry flag |
| ret_status_o | output | 1 | Restored status flag |

## Verification
A wrong frame index or step counter shows up at once on ram_addr_o. It appears in the first access cycle of the next push or pop, and in the cycle after the pointer step it is also visible on sp_o. A corrupted latch of the pushed data, or a bad nibble merge, reaches the ports as a wrong ram_wdata_o in the same cycle. On a pop it reaches them as a wrong restored word on the ret_valid_o pulse, one cycle after the fourth read. A wrong sequencer state breaks the four-cycle busy_o window or the exclusivity of the strobes within one cycle of the fault.

// File: rtl/nsc_pkg.sv
package nsc_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_PUSH = 2'd1,
    OP_POP  = 2'd2
  } op_e;
endpackage

// File: rtl/nsc_seq.sv
module nsc_seq
  import nsc_pkg::*;
#(
  parameter int unsigned NIBS   = 4,
  parameter int unsigned STEP_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic              reinit_i,
  output op_e               op_o,
  output logic [STEP_W-1:0] step_o,
  output logic              start_push_o,
  output logic              fin_push_o,
  output logic              fin_pop_o
);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NIBS - 1);

  op_e               op_q;
  logic [STEP_W-1:0] step_q;
  logic              last;

  assign last         = (op_q != OP_IDLE) && (step_q == LAST_STEP);
  assign start_push_o = (op_q == OP_IDLE) && push_i && !reinit_i;
  assign fin_push_o   = last && (op_q == OP_PUSH) && !reinit_i;
  assign fin_pop_o    = last && (op_q == OP_POP) && !reinit_i;
  assign op_o         = op_q;
  assign step_o       = step_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q   <= OP_IDLE;
      step_q <= '0;
    end else if (reinit_i) begin
      op_q   <= OP_IDLE;
      step_q <= '0;
    end else if (op_q == OP_IDLE) begin
      step_q <= '0;
      if (push_i)     op_q <= OP_PUSH;  // push wins over pop
      else if (pop_i) op_q <= OP_POP;
    end else if (last) begin
      op_q   <= OP_IDLE;
      step_q <= '0;
    end else begin
      step_q <= step_q + 1'b1;
    end
  end

  a_r7_idle_step_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_q == OP_IDLE) |-> (step_q == '0));

  a_r8_push_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_q == OP_IDLE && push_i && pop_i && !reinit_i) |=> (op_q == OP_PUSH));

  a_r7_busy_ignores: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_q != OP_IDLE && !last && !reinit_i) |=> (op_q == $past(op_q)));
endmodule

// File: rtl/nsc_ptr.sv
module nsc_ptr #(
  parameter int unsigned SLOT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dec_i,
  input  logic              inc_i,
  input  logic              reinit_i,
  output logic [SLOT_W-1:0] slot_o
);
  logic [SLOT_W-1:0] slot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       slot_q <= '1;
    else if (reinit_i) slot_q <= '1;
    else if (dec_i)    slot_q <= slot_q - 1'b1;  // wraps in the window
    else if (inc_i)    slot_q <= slot_q + 1'b1;
  end

  assign slot_o = slot_q;

  a_r10_no_dual_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dec_i && inc_i));

  a_r9_reinit_top: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reinit_i |=> (slot_o == '1));

  a_r7_hold_when_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dec_i && !inc_i && !reinit_i) |=> $stable(slot_o));
endmodule

// File: rtl/nsc_frame.sv
module nsc_frame #(
  parameter int unsigned PC_W   = 14,
  parameter int unsigned NIB_W  = 4,
  parameter int unsigned NIBS   = 4,
  parameter int unsigned STEP_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [PC_W-1:0]   pc_i,
  input  logic              carry_i,
  input  logic              status_i,
  input  logic              irq_i,
  input  logic [STEP_W-1:0] step_i,
  input  logic              capture_i,
  input  logic              fin_pop_i,
  input  logic [NIB_W-1:0]  rdata_i,
  output logic [NIB_W-1:0]  wdata_o,
  output logic [NIB_W-1:0]  wmask_o,
  output logic              ret_valid_o,
  output logic [PC_W-1:0]   ret_pc_o,
  output logic              ret_carry_o,
  output logic              ret_status_o
);
  localparam int unsigned FRAME_W = NIBS * NIB_W;

  logic [PC_W-1:0]    pc_q;
  logic               carry_q, status_q, irq_q;
  logic [FRAME_W-1:0] frame_w, acc_q, word_c;
  logic [NIB_W-1:0]   mask_tab [NIBS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q     <= '0;
      carry_q  <= 1'b0;
      status_q <= 1'b0;
      irq_q    <= 1'b0;
    end else if (load_i) begin
      pc_q     <= pc_i;
      carry_q  <= carry_i;
      status_q <= status_i;
      irq_q    <= irq_i;
    end
  end

  assign frame_w = FRAME_W'({status_q, carry_q, pc_q});
  assign wdata_o = frame_w[int'(step_i)*NIB_W +: NIB_W];

  // flag bits are only written on interrupt entry
  for (genvar n = 0; n < NIBS; n++) begin : g_nib
    for (genvar b = 0; b < NIB_W; b++) begin : g_bit
      localparam int unsigned IDX = n * NIB_W + b;
      if (IDX < PC_W) begin : g_pc
        assign mask_tab[n][b] = 1'b1;
      end else begin : g_flag
        assign mask_tab[n][b] = irq_q;
      end
    end
  end
  assign wmask_o = mask_tab[step_i];

  always_comb begin
    word_c = acc_q;
    word_c[(NIBS-1)*NIB_W +: NIB_W] = rdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q        <= '0;
      ret_valid_o  <= 1'b0;
      ret_pc_o     <= '0;
      ret_carry_o  <= 1'b0;
      ret_status_o <= 1'b0;
    end else begin
      if (capture_i) acc_q[int'(step_i)*NIB_W +: NIB_W] <= rdata_i;
      ret_valid_o <= fin_pop_i;
      if (fin_pop_i) begin
        ret_pc_o     <= word_c[PC_W-1:0];
        ret_carry_o  <= word_c[PC_W];
        ret_status_o <= word_c[PC_W+1];
      end
    end
  end

  a_r6_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_valid_o |=> !ret_valid_o);

  a_r4_call_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_q && step_i == STEP_W'(NIBS-1) && !capture_i) |-> (wmask_o != '1));
endmodule

// File: rtl/nib_stack_ctrl.sv
module nib_stack_ctrl
  import nsc_pkg::*;
#(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned FIX_W  = 4,
  parameter int unsigned PC_W   = 14,
  parameter int unsigned FLAG_W = 2,
  parameter int unsigned NIB_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic              push_irq_i,
  input  logic              pop_i,
  input  logic              sp_reinit_i,
  input  logic [PC_W-1:0]   pc_i,
  input  logic              carry_i,
  input  logic              status_i,
  input  logic [NIB_W-1:0]  ram_rdata_i,
  output logic [ADDR_W-1:0] sp_o,
  output logic              busy_o,
  output logic [ADDR_W-1:0] ram_addr_o,
  output logic              ram_we_o,
  output logic [NIB_W-1:0]  ram_wdata_o,
  output logic [NIB_W-1:0]  ram_wmask_o,
  output logic              ram_re_o,
  output logic              ret_valid_o,
  output logic [PC_W-1:0]   ret_pc_o,
  output logic              ret_carry_o,
  output logic              ret_status_o
);
  localparam int unsigned NIBS    = (PC_W + FLAG_W + NIB_W - 1) / NIB_W;
  localparam int unsigned LOW_W   = $clog2(NIBS);
  localparam int unsigned SLOT_W  = ADDR_W - FIX_W - LOW_W;
  localparam int unsigned SLOT_HI = ADDR_W - FIX_W - 1;
  localparam logic [FIX_W-1:0] FIX_PAT  = '1;
  localparam logic [LOW_W-1:0] LOW_TOP  = LOW_W'(NIBS - 1);

  op_e               op;
  logic [LOW_W-1:0]  step;
  logic              start_push, fin_push, fin_pop;
  logic [SLOT_W-1:0] slot, slot_above, slot_acc;

  nsc_seq #(.NIBS(NIBS), .STEP_W(LOW_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (push_i),
    .pop_i       (pop_i),
    .reinit_i    (sp_reinit_i),
    .op_o        (op),
    .step_o      (step),
    .start_push_o(start_push),
    .fin_push_o  (fin_push),
    .fin_pop_o   (fin_pop)
  );

  nsc_ptr #(.SLOT_W(SLOT_W)) u_ptr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .dec_i   (fin_push),
    .inc_i   (fin_pop),
    .reinit_i(sp_reinit_i),
    .slot_o  (slot)
  );

  nsc_frame #(.PC_W(PC_W), .NIB_W(NIB_W), .NIBS(NIBS), .STEP_W(LOW_W)) u_frame (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (start_push),
    .pc_i        (pc_i),
    .carry_i     (carry_i),
    .status_i    (status_i),
    .irq_i       (push_irq_i),
    .step_i      (step),
    .capture_i   (ram_re_o),
    .fin_pop_i   (fin_pop),
    .rdata_i     (ram_rdata_i),
    .wdata_o     (ram_wdata_o),
    .wmask_o     (ram_wmask_o),
    .ret_valid_o (ret_valid_o),
    .ret_pc_o    (ret_pc_o),
    .ret_carry_o (ret_carry_o),
    .ret_status_o(ret_status_o)
  );

  assign slot_above = slot + 1'b1;
  assign slot_acc   = (op == OP_POP) ? slot_above : slot;
  assign sp_o       = {FIX_PAT, slot, LOW_TOP};
  assign ram_addr_o = {FIX_PAT, slot_acc, LOW_TOP - step};
  assign ram_we_o   = (op == OP_PUSH);
  assign ram_re_o   = (op == OP_POP);
  assign busy_o     = (op != OP_IDLE);

  a_r10_strobe_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ram_we_o && ram_re_o) && (busy_o || (!ram_we_o && !ram_re_o)));

  a_r3_push_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ram_we_o && ram_addr_o[LOW_W-1:0] == '0 && !sp_reinit_i)
      |=> (sp_o[SLOT_HI:LOW_W] == SLOT_W'($past(sp_o[SLOT_HI:LOW_W]) - 1'b1)));

  a_r5_pop_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ram_re_o && ram_addr_o[LOW_W-1:0] == '0 && !sp_reinit_i)
      |=> (sp_o[SLOT_HI:LOW_W] == SLOT_W'($past(sp_o[SLOT_HI:LOW_W]) + 1'b1)) && ret_valid_o);

  a_r2_write_in_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |-> (ram_addr_o[ADDR_W-1:LOW_W] == sp_o[ADDR_W-1:LOW_W]));

  a_r9_reinit_sp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sp_reinit_i |=> (sp_o == '1) && !busy_o && !ret_valid_o);

  a_r6_valid_after_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_valid_o |-> $past(ram_re_o));
endmodule

// File: tb/nib_stack_ctrl_tb_top.sv
`timescale 1ns/1ps
module nib_stack_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        push = 1'b0, push_irq = 1'b0, pop = 1'b0, reinit = 1'b0;
  logic [13:0] pc = '0;
  logic        carry = 1'b0, status = 1'b0;
  logic [3:0]  rdata;
  logic [9:0]  sp, addr;
  logic        busy, we, re, rv, rc, rs;
  logic [3:0]  wdata, wmask;
  logic [13:0] rpc;

  logic [3:0] mem [1024];
  int total = 0, bad = 0;

  // reference model state
  int f, phase, step;
  logic [13:0] m_pc; logic m_c, m_s, m_irq;
  logic [15:0] m_acc;
  logic e_rv; logic [13:0] e_rpc; logic e_rc, e_rs;
  int unsigned seed = 32'h1234_5678;

  always #10 clk = ~clk;

  assign rdata = mem[addr];

  nib_stack_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .push_i(push), .push_irq_i(push_irq), .pop_i(pop),
    .sp_reinit_i(reinit), .pc_i(pc), .carry_i(carry), .status_i(status),
    .ram_rdata_i(rdata), .sp_o(sp), .busy_o(busy), .ram_addr_o(addr), .ram_we_o(we),
    .ram_wdata_o(wdata), .ram_wmask_o(wmask), .ram_re_o(re), .ret_valid_o(rv),
    .ret_pc_o(rpc), .ret_carry_o(rc), .ret_status_o(rs)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int exp_addr();
    int s;
    s = (phase == 2) ? (f + 1) % 16 : f;
    return 32'h3C0 | (s << 2) | (3 - step);
  endfunction

  function automatic logic [3:0] exp_wdata();
    logic [15:0] w;
    w = {m_s, m_c, m_pc};
    return w[step*4 +: 4];
  endfunction

  function automatic logic [3:0] exp_mask();
    return (step == 3 && !m_irq) ? 4'b0011 : 4'b1111;
  endfunction

  task automatic model_edge();
    int a;
    a = exp_addr();
    if (phase == 1) begin
      for (int b = 0; b < 4; b++) if (exp_mask()[b]) mem[a][b] = exp_wdata()[b];
    end else if (phase == 2) begin
      m_acc[step*4 +: 4] = mem[a];
    end
    e_rv = 1'b0;
    if (reinit) begin
      f = 15; phase = 0; step = 0;
    end else if (phase == 0) begin
      if (push) begin
        phase = 1; step = 0; m_pc = pc; m_c = carry; m_s = status; m_irq = push_irq;
      end else if (pop) begin
        phase = 2; step = 0;
      end
    end else if (step == 3) begin
      if (phase == 1) f = (f + 15) % 16;
      else begin
        f = (f + 1) % 16; e_rv = 1'b1;
        e_rpc = m_acc[13:0]; e_rc = m_acc[14]; e_rs = m_acc[15];
      end
      phase = 0; step = 0;
    end else step++;
  endtask

  task automatic compare();
    chk("R3 sp", 32'(sp), 32'h3C3 | (f << 2));
    chk("R7 busy", 32'(busy), 32'(phase != 0));
    chk("R2 we", 32'(we), 32'(phase == 1));
    chk("R5 re", 32'(re), 32'(phase == 2));
    chk("R10 strobes", 32'(we & re), 32'd0);
    if (phase != 0) chk("R2/R5 addr", 32'(addr), exp_addr());
    if (phase == 1) begin
      chk("R2 wdata", 32'(wdata), 32'(exp_wdata()));
      chk("R4 wmask", 32'(wmask), 32'(exp_mask()));
    end
    chk("R6 ret_valid", 32'(rv), 32'(e_rv));
    if (e_rv) chk("R6 ret word", {16'd0, rs, rc, rpc}, {16'd0, e_rs, e_rc, e_rpc});
  endtask

  task automatic cyc();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
  endtask

  task automatic do_push(input logic [13:0] p, input logic c, input logic s, input logic irq);
    push = 1'b1; push_irq = irq; pc = p; carry = c; status = s;
    cyc();
    push = 1'b0; push_irq = 1'b0;
    for (int i = 0; i < 4; i++) cyc();
  endtask

  task automatic do_pop();
    pop = 1'b1; cyc(); pop = 1'b0;
    for (int i = 0; i < 5; i++) cyc();
  endtask

  initial begin
    #(200000 * 20);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 4'(i * 7 + 3);
    f = 15; phase = 0; step = 0; e_rv = 1'b0; e_rpc = '0; e_rc = 0; e_rs = 0;
    m_pc = '0; m_c = 0; m_s = 0; m_irq = 0; m_acc = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 sp", 32'(sp), 32'h3FF);
    chk("R1 busy", 32'(busy), 0);
    chk("R1 strobes", 32'(we | re), 0);
    compare();

    // R2/R4 call push, with requests during busy (R7)
    push = 1'b1; pc = 14'h1A5C; carry = 1; status = 1; cyc();
    push = 1'b1; pop = 1'b1; pc = 14'h0001; cyc(); cyc();
    push = 1'b0; pop = 1'b0; cyc(); cyc();
    chk("R7 push ignored while busy", 32'(sp), 32'h3FB);
    do_push(14'h2F0F, 1'b1, 1'b0, 1'b1);
    do_pop();
    do_pop();
    chk("R5 back to top", 32'(sp), 32'h3FF);

    // R8 simultaneous requests
    push = 1'b1; pop = 1'b1; pc = 14'h3333; cyc();
    push = 1'b0; pop = 1'b0;
    chk("R8 push taken", 32'(we), 32'd1);
    repeat (4) cyc();
    chk("R8 sp after", 32'(sp), 32'h3FB);

    // R3 wrap by 17 pushes, R5 wrap by pops
    for (int i = 0; i < 17; i++) do_push(14'(i * 977), i[0], i[1], i[2]);
    for (int i = 0; i < 18; i++) do_pop();

    // R9 reinit during push and during last pop read
    do_push(14'h0ABC, 1, 0, 1);
    push = 1'b1; pc = 14'h1111; cyc(); push = 1'b0; cyc();
    reinit = 1'b1; cyc(); reinit = 1'b0;
    chk("R9 reinit mid push", 32'(sp), 32'h3FF);
    chk("R9 idle after", 32'(busy), 0);
    do_push(14'h2222, 0, 1, 1);
    pop = 1'b1; cyc(); pop = 1'b0; cyc(); cyc(); cyc();
    reinit = 1'b1; cyc(); reinit = 1'b0; cyc();
    chk("R9 no ret pulse", 32'(rv), 0);
    // R9 priority over push
    reinit = 1'b1; push = 1'b1; cyc(); reinit = 1'b0; push = 1'b0;
    chk("R9 beats push", 32'(busy), 0);

    // mixed traffic
    for (int i = 0; i < 1500; i++) begin
      seed = seed ^ (seed << 13); seed = seed ^ (seed >> 17); seed = seed ^ (seed << 5);
      push = seed[0]; pop = seed[1]; push_irq = seed[2];
      reinit = (seed[9:4] == 6'd0);
      pc = seed[27:14]; carry = seed[28]; status = seed[29];
      cyc();
    end
    push = 0; pop = 0; reinit = 0;
    repeat (8) cyc();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule